// File: doc/BRIEF.md
# Inter-core doorbell register bank

This block holds one doorbell register per destination core in a multi-core cluster. Any core can reach any register through its own simple register port. A write to a destination's doorbell address can set sender-identity flags and can fire a one-cycle interrupt pulse toward that destination. Because only ones take effect, a sender writes just its own identity bit and the trigger bit, and never reads first. This means concurrent senders cannot overwrite one another.

The destination core reads its doorbell to see which senders have signalled. It then writes ones to a separate acknowledge address to clear the flags it has handled. Each sender waits for its flag to drop before it signals the same destination again. Writes from all ports are merged in the same cycle, and a set always wins over a clear, so no sender's flag is lost under heavy traffic.

Register layout, with N cores: bit 0 is the trigger and is not stored. Bit k+1 is the identity flag of core k. Address bit DEST_W selects the access kind: 0 is the doorbell and 1 is the acknowledge. Address bits [DEST_W-1:0] give the destination index, where DEST_W = clog2(N)+1. An index of N or above names no destination.

Top module: `icg_doorbell`

## Requirements
- R1: While reset is asserted and right after it, every identity flag, every `irq_o` bit and every `rdata_o` word is 0.
- R2: A doorbell write to destination d ORs data bits [N:1] into d's identity flags. Zero data bits leave their flags unchanged.
- R3: A doorbell write with data bit 0 set drives `irq_o[d]` high for exactly the cycle after the write, unless a trigger write also arrives in that cycle. Bit 0 is never stored and always reads back as 0.
- R4: Doorbell writes from several ports to one destination in the same cycle are all merged by OR. Several simultaneous trigger writes give one single-cycle pulse.
- R5: An acknowledge write to destination d clears every identity flag whose data bit is 1 (bits [N:1]). Zero bits and data bit 0 have no effect.
- R6: When a set and a clear reach the same identity flag of one destination in the same cycle, the flag is 1 afterwards.
- R7: A read (`req_i`=1, `we_i`=0) of either address of destination d loads {flags(d), 1'b0} into that port's `rdata_o` at the next edge. The flags sampled are those before any write in the same cycle. `rdata_o` holds until the port's next read, and a read changes no flag.
- R8: Writes to a destination index of N or above change nothing, and reads of such an index return 0.
- R9: A write to one destination changes no other destination's flags or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_PORTS | Access request, one per port |
| we_i | input | NUM_PORTS | Write enable, one per port (0 = read) |
| addr_i | input | NUM_PORTS x (DEST_W+1) | Kind bit (MSB) and destination index, per port |
| wdata_i | input | NUM_PORTS x (NUM_CORES+1) | Write data, per port |
| rdata_o | output | NUM_PORTS x (NUM_CORES+1) | Registered read data, per port |
| irq_o | output | NUM_CORES | Interrupt pulse, one per destination |

## Verification
Two functions can fall in the same cycle and reach the same register: a sender's doorbell set, and the destination's acknowledge clear of the same identity flag. Often a read of that register comes in the same cycle as well. The bench works on a four-core build. For every destination, it preloads each flag pattern, then sweeps all set masks on one port against all clear masks on another, with a third port reading. Each result is judged against an arithmetic model, new = (old & ~clear) | set, and the same-cycle read must return the old value.

// File: rtl/icg_pkg.sv
package icg_pkg;
  typedef enum logic {
    ACC_GEN = 1'b0,
    ACC_ACK = 1'b1
  } icg_acc_e;

  function automatic int dest_width(int num_cores);
    return $clog2(num_cores) + 1;
  endfunction
endpackage

// File: rtl/icg_port_decode.sv
module icg_port_decode
  import icg_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int DEST_W    = 4,
  parameter int ADDR_W    = DEST_W + 1,
  parameter int REG_W     = NUM_CORES + 1
) (
  input  logic                                 req_i,
  input  logic                                 we_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [REG_W-1:0]                     wdata_i,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0]  set_o,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0]  clr_o,
  output logic [NUM_CORES-1:0]                 trig_o
);
  logic              wr;
  logic [DEST_W-1:0] dest;
  icg_acc_e          kind;

  assign wr   = req_i & we_i;
  assign dest = addr_i[DEST_W-1:0];
  assign kind = icg_acc_e'(addr_i[ADDR_W-1]);

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_dest
    logic hit;
    assign hit       = wr && (dest == DEST_W'(d));
    assign set_o[d]  = (hit && kind == ACC_GEN) ? wdata_i[REG_W-1:1] : '0;
    assign clr_o[d]  = (hit && kind == ACC_ACK) ? wdata_i[REG_W-1:1] : '0;
    assign trig_o[d] = hit && (kind == ACC_GEN) && wdata_i[0];
  end
endmodule

// File: rtl/icg_dest_reg.sv
module icg_dest_reg #(
  parameter int NUM_CORES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] set_i,
  input  logic [NUM_CORES-1:0] clr_i,
  input  logic                 trig_i,
  output logic [NUM_CORES-1:0] flags_o,
  output logic                 irq_o
);
  logic [NUM_CORES-1:0] flags_q;
  logic                 irq_q;

  // set applied after clear: set wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_i;
      irq_q   <= trig_i;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/icg_read_port.sv
module icg_read_port #(
  parameter int NUM_CORES = 8,
  parameter int DEST_W    = 4,
  parameter int REG_W     = NUM_CORES + 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                rd_i,
  input  logic [DEST_W-1:0]                   dest_i,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] flags_i,
  output logic [REG_W-1:0]                    rdata_o
);
  logic [NUM_CORES-1:0] sel;
  logic [REG_W-1:0]     rdata_q;

  always_comb begin
    sel = '0;
    for (int d = 0; d < NUM_CORES; d++) begin
      if (dest_i == DEST_W'(d)) sel = flags_i[d];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= {sel, 1'b0};
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/icg_doorbell.sv
module icg_doorbell
  import icg_pkg::*;
#(
  parameter  int NUM_CORES = 8,
  parameter  int NUM_PORTS = NUM_CORES,
  localparam int DEST_W    = dest_width(NUM_CORES),
  localparam int ADDR_W    = DEST_W + 1,
  localparam int REG_W     = NUM_CORES + 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              req_i,
  input  logic [NUM_PORTS-1:0]              we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NUM_PORTS-1:0][REG_W-1:0]   wdata_i,
  output logic [NUM_PORTS-1:0][REG_W-1:0]   rdata_o,
  output logic [NUM_CORES-1:0]              irq_o
);
  logic [NUM_PORTS-1:0][NUM_CORES-1:0][NUM_CORES-1:0] port_set, port_clr;
  logic [NUM_PORTS-1:0][NUM_CORES-1:0]                port_trig;
  logic [NUM_CORES-1:0][NUM_CORES-1:0]                set_m, clr_m;
  logic [NUM_CORES-1:0]                               trig_m;
  logic [NUM_CORES-1:0][NUM_CORES-1:0]                flags;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    icg_port_decode #(
      .NUM_CORES(NUM_CORES), .DEST_W(DEST_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
    ) u_dec (
      .req_i  (req_i[p]),
      .we_i   (we_i[p]),
      .addr_i (addr_i[p]),
      .wdata_i(wdata_i[p]),
      .set_o  (port_set[p]),
      .clr_o  (port_clr[p]),
      .trig_o (port_trig[p])
    );

    icg_read_port #(
      .NUM_CORES(NUM_CORES), .DEST_W(DEST_W), .REG_W(REG_W)
    ) u_rd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rd_i   (req_i[p] & ~we_i[p]),
      .dest_i (addr_i[p][DEST_W-1:0]),
      .flags_i(flags),
      .rdata_o(rdata_o[p])
    );
  end

  // merge all ports: OR keeps every sender
  always_comb begin
    set_m  = '0;
    clr_m  = '0;
    trig_m = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_m  = set_m  | port_set[p];
      clr_m  = clr_m  | port_clr[p];
      trig_m = trig_m | port_trig[p];
    end
  end

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_dest
    icg_dest_reg #(.NUM_CORES(NUM_CORES)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_m[d]),
      .clr_i  (clr_m[d]),
      .trig_i (trig_m[d]),
      .flags_o(flags[d]),
      .irq_o  (irq_o[d])
    );
  end
endmodule

// File: rtl/icg_doorbell_chk.sv
module icg_doorbell_chk #(
  parameter int NUM_CORES = 8,
  parameter int NUM_PORTS = NUM_CORES,
  parameter int DEST_W    = $clog2(NUM_CORES) + 1,
  parameter int ADDR_W    = DEST_W + 1,
  parameter int REG_W     = NUM_CORES + 1
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_PORTS-1:0]              req_i,
  input logic [NUM_PORTS-1:0]              we_i,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input logic [NUM_PORTS-1:0][REG_W-1:0]   wdata_i,
  input logic [NUM_PORTS-1:0][REG_W-1:0]   rdata_o,
  input logic [NUM_CORES-1:0]              irq_o,
  input logic [NUM_CORES-1:0][NUM_CORES-1:0] flags_i
);
  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_seen, clr_seen;
  logic [NUM_CORES-1:0]                trig_seen;

  always_comb begin
    set_seen  = '0;
    clr_seen  = '0;
    trig_seen = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int d = 0; d < NUM_CORES; d++) begin
        if (req_i[p] && we_i[p] && addr_i[p][DEST_W-1:0] == DEST_W'(d)) begin
          if (!addr_i[p][ADDR_W-1]) begin
            set_seen[d]  = set_seen[d] | wdata_i[p][REG_W-1:1];
            trig_seen[d] = trig_seen[d] | wdata_i[p][0];
          end else begin
            clr_seen[d] = clr_seen[d] | wdata_i[p][REG_W-1:1];
          end
        end
      end
    end
  end

  for (genvar d = 0; d < NUM_CORES; d++) begin : g_d
    a_r3_trig_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_seen[d] |=> irq_o[d]);
    a_r4_no_spurious_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trig_seen[d] |=> !irq_o[d]);
    a_r2_rise_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[d] & ~$past(flags_i[d]) & ~$past(set_seen[d])) == '0);
    a_r5_fall_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(flags_i[d]) & ~flags_i[d] & ~$past(clr_seen[d])) == '0);
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(flags_i[d]) & ~flags_i[d] & $past(set_seen[d])) == '0);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    a_r7_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i[p] && !we_i[p]) |=> $stable(rdata_o[p]));
  end
endmodule

bind icg_doorbell icg_doorbell_chk #(
  .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .flags_i(flags)
);

// File: tb/icg_doorbell_bench.sv
module icg_doorbell_bench;
  localparam int NC = 4;
  localparam int NP = 4;
  localparam int DW = $clog2(NC) + 1;
  localparam int AW = DW + 1;
  localparam int RW = NC + 1;
  localparam int ND = 1 << DW;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NP-1:0]          req = '0;
  logic [NP-1:0]          we = '0;
  logic [NP-1:0][AW-1:0]  addr = '0;
  logic [NP-1:0][RW-1:0]  wdata = '0;
  logic [NP-1:0][RW-1:0]  rdata;
  logic [NC-1:0]          irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [NC-1:0] m_flags [NC];
  logic [RW-1:0] m_rd    [NP];

  always #2 clk = ~clk;

  icg_doorbell #(.NUM_CORES(NC), .NUM_PORTS(NP)) u_icg_doorbell (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic op(int p, bit wr, bit ack, int dest, logic [RW-1:0] data);
    req[p]   = 1'b1;
    we[p]    = wr;
    addr[p]  = {ack, DW'(dest)};
    wdata[p] = data;
  endtask

  // one cycle: model, clock, compare at next negedge
  task automatic step(string tag);
    logic [NC-1:0] setm [NC];
    logic [NC-1:0] clrm [NC];
    logic [NC-1:0] trig;
    trig = '0;
    for (int d = 0; d < NC; d++) begin setm[d] = '0; clrm[d] = '0; end
    for (int p = 0; p < NP; p++) begin
      int dest;
      dest = int'(addr[p][DW-1:0]);
      if (req[p] && !we[p])
        m_rd[p] = (dest < NC) ? {m_flags[dest], 1'b0} : '0;
      else if (req[p] && we[p] && dest < NC) begin
        if (!addr[p][AW-1]) begin
          setm[dest] |= wdata[p][RW-1:1];
          trig[dest] |= wdata[p][0];
        end else
          clrm[dest] |= wdata[p][RW-1:1];
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < NC; d++) m_flags[d] = (m_flags[d] & ~clrm[d]) | setm[d];
    chk({tag, " irq"}, 32'(irq), 32'(trig));
    for (int p = 0; p < NP; p++) chk({tag, " rdata"}, 32'(rdata[p]), 32'(m_rd[p]));
    req = '0; we = '0; addr = '0; wdata = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < NC; d++) m_flags[d] = '0;
    for (int p = 0; p < NP; p++) m_rd[p] = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    for (int p = 0; p < NP; p++) chk("R1 rdata", 32'(rdata[p]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < NC; d++) begin
      op(0, 0, 0, d, '0);
      step("R1 flags");
    end

    // R2/R3/R8/R9: every port to every index, valid or not
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < NP; p++) begin
        op(p, 1, 0, d, RW'((1 << (p + 1)) | (p % 2)));
        step(d < NC ? "R2 R3 set+trigger" : "R8 bad dest write");
        step("R3 pulse ends");
      end
      for (int p = 0; p < NP; p++) op(p, 0, p % 2, (d + p) % ND, '0);
      step("R9 R8 reads");
      for (int p = 0; p < NP; p++) op(p, 0, 0, (d + p) % ND, '0);
      step("R7 read twice");
      op(1, 1, 1, d, '1);
      step("R5 ack all");
    end

    // R4: all ports trigger the same destination at once
    for (int d = 0; d < NC; d++) begin
      for (int p = 0; p < NP; p++) op(p, 1, 0, d, RW'((1 << (p + 1)) | 1));
      step("R4 merged");
      op(0, 0, 0, d, '0);
      step("R4 single pulse");
      op(0, 1, 1, d, '1);
      step("R4 cleanup");
    end

    // R6/R5/R7: set vs clear, every mask pair, same-cycle read
    for (int d = 0; d < NC; d++) begin
      for (int s = 0; s < 16; s++) begin
        for (int c = 0; c < 16; c++) begin
          op(0, 1, 1, d, '1);
          step("R5 preclear");
          op(0, 1, 0, d, RW'(((c ^ s ^ 5) & 15) << 1));
          step("R2 preload");
          op(1, 1, 0, d, RW'(s << 1));
          op(2, 1, 1, d, RW'((c << 1) | 1));
          op(3, 0, 0, d, '0);
          step("R6 set vs clear");
          op(0, 0, 1, d, '0);
          step("R6 result");
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule